// File: doc/BRIEF.md
# Audio Port Control and Status Register File

This block is the bus-facing register file of a serial audio port. It holds one control register, which drives the port's run, interrupt-enable and format settings, and one status register, which shows the port's busy state and two sticky FIFO error flags. A single-cycle read/write bus reaches each register at three addresses. The base address replaces the whole register. Base plus 0x4 sets the bits that are 1 in the write data. Base plus 0x8 clears the bits that are 1 in the write data. Software can therefore change one field without a read-modify-write.

Two control bits, a local reset request and a clock gate, come out of reset set. They lock every other control field until software has cleared both. The port reports FIFO underflow and overflow as one-cycle event pulses. Each pulse latches a flag that stays set until software clears it through the status clear alias. A registered interrupt output is raised while the error interrupt enable is set and either flag is set.

Top module: `aport_csr`

## Requirements
- R1: After reset, the control register reads 0xC000_0000: bit 31 (local reset request) and bit 30 (clock gate) are 1 and all other bits are 0. The status flags, `irq_o` and `rdata_o` are 0.
- R2: When the control register is unlocked, a write to its base address (0x00) replaces it. Only the defined bits are stored: bit 0 run, bit 1 error interrupt enable, bit 2 receive mode, bits 4:3 word length, bit 5 bit-clock edge, bit 6 frame polarity, bit 7 one-bit data delay, bit 8 follower clocking, bit 9 384x base rate, bits 12:10 master-clock divider, plus bits 31:30. Undefined bits read 0.
- R3: A write to base + 0x4 ORs the write data into the register.
- R4: A write to base + 0x8 clears every register bit whose write-data bit is 1.
- R5: While bit 31 or bit 30 of the control register is 1, any write can change only those two bits. All other control fields keep their values. The lock is judged on the register value before the write.
- R6: Reads through the base, set and clear aliases all return the current register value in `rdata_o`, one cycle after the address is presented. Offset 0xC within a register block, misaligned addresses and unmapped addresses read 0 and ignore writes. The status block sits at 0x10.
- R7: Status bit 0 shows `busy_i` as it is at the read edge. No write alias changes it.
- R8: Status bit 1 (underflow) and bit 2 (overflow) are set by a pulse on `underflow_i` or `overflow_i`. A flag stays set until a 1 is written to its bit at the status clear alias (0x18). Writes to 0x10 and 0x14 do not change the flags.
- R9: If an error event arrives in the same cycle that its flag is cleared, the flag stays set.
- R10: `irq_o` is 1 in the cycle after control bit 1 is 1 and either flag is 1, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable; high for one cycle per write |
| rdata_o | output | 32 | Registered read data for the address of the previous cycle |
| busy_i | input | 1 | Transfer-in-progress indication from the port |
| underflow_i | input | 1 | FIFO underflow event pulse |
| overflow_i | input | 1 | FIFO overflow event pulse |
| ctrl_o | output | 32 | Current control register value, driving the port |
| irq_o | output | 1 | Registered FIFO error interrupt |

## Verification
A write or event takes effect at the clock edge where it is sampled. A read address presented before edge k returns, just after edge k, the register value from before that edge. `irq_o` follows the enable and flags one edge later than the flags themselves. Each driver task records the edge at which its result is due. The monitor compares results 2 ns after that exact edge, so a result that arrives one cycle early or late is caught as a mismatch.

// File: rtl/aport_csr_pkg.sv
package aport_csr_pkg;
  localparam int REG_W = 32;

  // control field positions
  localparam int CB_RUN     = 0;
  localparam int CB_IRQEN   = 1;
  localparam int CB_RXMODE  = 2;
  localparam int CB_WLEN    = 3;   // two bits
  localparam int CB_EDGE    = 5;
  localparam int CB_FPOL    = 6;
  localparam int CB_DELAY   = 7;
  localparam int CB_FOLLOW  = 8;
  localparam int CB_BASE384 = 9;
  localparam int CB_MDIV    = 10;  // three bits
  localparam int CB_GATE    = 30;
  localparam int CB_SRST    = 31;

  localparam logic [REG_W-1:0] LOCK_MASK =
    (REG_W'(1) << CB_SRST) | (REG_W'(1) << CB_GATE);
  localparam logic [REG_W-1:0] FIELD_MASK = (REG_W'(1) << (CB_MDIV + 3)) - REG_W'(1);
  localparam logic [REG_W-1:0] CTRL_MASK  = FIELD_MASK | LOCK_MASK;
  localparam logic [REG_W-1:0] CTRL_RST   = LOCK_MASK;

  // status field positions
  localparam int SB_BUSY = 0;
  localparam int SB_UF   = 1;
  localparam int SB_OF   = 2;
  localparam int NFLAG   = 2;

  typedef enum logic [1:0] {
    AL_PLAIN = 2'd0,
    AL_SET   = 2'd1,
    AL_CLR   = 2'd2,
    AL_RSVD  = 2'd3
  } alias_e;

  function automatic logic [REG_W-1:0] apply_alias(
    input alias_e a, input logic [REG_W-1:0] cur, input logic [REG_W-1:0] wd);
    case (a)
      AL_PLAIN: apply_alias = wd;
      AL_SET:   apply_alias = cur | wd;
      AL_CLR:   apply_alias = cur & ~wd;
      default:  apply_alias = cur;
    endcase
  endfunction
endpackage

// File: rtl/aport_csr_decode.sv
module aport_csr_decode
  import aport_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 'h00,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output alias_e            alias_o,
  output logic              ctrl_sel_o,
  output logic              stat_sel_o,
  output logic              ctrl_wr_o,
  output logic              stat_wr_o
);
  localparam int BLK_LSB = 4;

  logic [ADDR_W-BLK_LSB-1:0] page;
  logic                      valid;

  always_comb begin
    page       = addr_i[ADDR_W-1:BLK_LSB];
    alias_o    = alias_e'(addr_i[3:2]);
    valid      = (addr_i[1:0] == 2'b00) && (alias_o != AL_RSVD);
    ctrl_sel_o = valid && (page == CTRL_BASE[ADDR_W-1:BLK_LSB]);
    stat_sel_o = valid && (page == STAT_BASE[ADDR_W-1:BLK_LSB]);
    ctrl_wr_o  = we_i && ctrl_sel_o;
    stat_wr_o  = we_i && stat_sel_o;
  end
endmodule

// File: rtl/aport_csr_ctrl.sv
module aport_csr_ctrl
  import aport_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  alias_e           alias_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_q
);
  logic             locked;
  logic [REG_W-1:0] cand;
  logic [REG_W-1:0] nxt;

  always_comb begin
    locked = ctrl_q[CB_SRST] | ctrl_q[CB_GATE];
    cand   = apply_alias(alias_i, ctrl_q, wdata_i) & CTRL_MASK;
    if (!wr_i)
      nxt = ctrl_q;
    else if (locked)
      nxt = (ctrl_q & ~LOCK_MASK) | (cand & LOCK_MASK);
    else
      nxt = cand;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_RST;
    else     ctrl_q <= nxt;
  end

  // R5: locked fields hold across any write
  a_r5_lock_hold: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CB_SRST] || ctrl_q[CB_GATE]) |=>
      ((ctrl_q & ~LOCK_MASK) == ($past(ctrl_q) & ~LOCK_MASK)));

  // R2: unlocked plain write lands as masked data
  a_r2_plain_write: assert property (@(posedge clk) disable iff (rst)
    (wr_i && alias_i == AL_PLAIN && !ctrl_q[CB_SRST] && !ctrl_q[CB_GATE]) |=>
      (ctrl_q == ($past(wdata_i) & CTRL_MASK)));
endmodule

// File: rtl/aport_csr_stat.sv
module aport_csr_stat
  import aport_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  alias_e           alias_i,
  input  logic [NFLAG-1:0] wbits_i,
  input  logic             busy_i,
  input  logic [NFLAG-1:0] event_i,
  output logic [NFLAG-1:0] flag_q,
  output logic [REG_W-1:0] stat_o
);
  logic clr_alias;
  assign clr_alias = wr_i && (alias_i == AL_CLR);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic clr;
    assign clr = clr_alias && wbits_i[i];

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= event_i[i] | (flag_q[i] & ~clr);
    end

    // R8: a flag only drops through a clear-alias write
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !clr) |=> flag_q[i]);

    // R9: an event always leaves its flag set
    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
      event_i[i] |=> flag_q[i]);
  end

  always_comb begin
    stat_o          = '0;
    stat_o[SB_BUSY] = busy_i;
    stat_o[SB_UF]   = flag_q[0];
    stat_o[SB_OF]   = flag_q[1];
  end
endmodule

// File: rtl/aport_csr.sv
module aport_csr
  import aport_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 'h00,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              underflow_i,
  input  logic              overflow_i,
  output logic [REG_W-1:0]  ctrl_o,
  output logic              irq_o
);
  alias_e           alias_s;
  logic             ctrl_sel, stat_sel, ctrl_wr, stat_wr;
  logic [REG_W-1:0] ctrl_q, stat_v;
  logic [NFLAG-1:0] flags;

  aport_csr_decode #(
    .ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE), .STAT_BASE(STAT_BASE)
  ) u_dec (
    .addr_i(addr_i), .we_i(we_i), .alias_o(alias_s),
    .ctrl_sel_o(ctrl_sel), .stat_sel_o(stat_sel),
    .ctrl_wr_o(ctrl_wr), .stat_wr_o(stat_wr)
  );

  aport_csr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_i(ctrl_wr), .alias_i(alias_s),
    .wdata_i(wdata_i), .ctrl_q(ctrl_q)
  );

  aport_csr_stat u_stat (
    .clk(clk), .rst(rst), .wr_i(stat_wr), .alias_i(alias_s),
    .wbits_i(wdata_i[SB_OF:SB_UF]), .busy_i(busy_i),
    .event_i({overflow_i, underflow_i}), .flag_q(flags), .stat_o(stat_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (ctrl_sel)      rdata_o <= ctrl_q;
      else if (stat_sel) rdata_o <= stat_v;
      else               rdata_o <= '0;
      irq_o <= ctrl_q[CB_IRQEN] & (|flags);
    end
  end

  assign ctrl_o = ctrl_q;

  // R10: no interrupt after a cycle with the enable low
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !ctrl_o[CB_IRQEN] |=> !irq_o);

  // R10: enabled error flag raises the interrupt next cycle
  a_r10_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (ctrl_o[CB_IRQEN] && (flags != '0)) |=> irq_o);

  // R6: one write reaches at most one register
  a_r6_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl_wr, stat_wr}));
endmodule

// File: tb/aport_csr_tb_top.sv
module aport_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        busy = 1'b0, uf = 1'b0, of = 1'b0;
  logic [31:0] rdata, ctrl;
  logic        irq;

  always #5 clk = ~clk;

  aport_csr dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .busy_i(busy), .underflow_i(uf), .overflow_i(of),
    .ctrl_o(ctrl), .irq_o(irq)
  );

  int          cyc = 0;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;
  int          due_q[$];
  int          src_q[$];   // 0 rdata, 1 irq, 2 ctrl_o
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // monitor: compare each item just after the edge it is due at
  always @(posedge clk) begin
    #2;
    cyc++;
    while (due_q.size() > 0 && due_q[0] == cyc) begin
      logic [31:0] act;
      int s;
      s = src_q.pop_front();
      act = (s == 0) ? rdata : (s == 1) ? {31'b0, irq} : ctrl;
      n_run++;
      if (act !== exp_q[0]) begin
        n_fail++;
        $display("FAIL %s: src %0d actual 0x%08h expected 0x%08h", tag_q[0], s, act, exp_q[0]);
      end
      void'(due_q.pop_front());
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic expect_item(int src, logic [31:0] e, string tag);
    due_q.push_back(cyc + 1);
    src_q.push_back(src);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    addr = a; we = 1'b0;
    expect_item(0, e, tag);
    @(negedge clk);
  endtask

  task automatic chk_irq(logic e, string tag);
    expect_item(1, {31'b0, e}, tag);
    @(negedge clk);
  endtask

  task automatic chk_ctrl(logic [31:0] e, string tag);
    expect_item(2, e, tag);
    @(negedge clk);
  endtask

  task automatic pulse(logic u, logic o);
    uf = u; of = o;
    @(negedge clk);
    uf = 1'b0; of = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    rd(8'h00, 32'hC000_0000, "R1 ctrl");
    rd(8'h10, 32'h0, "R1 status");
    chk_irq(1'b0, "R1 irq");
    // R5 locked: set alias cannot touch fields
    wr(8'h04, 32'h0000_0003);
    rd(8'h00, 32'hC000_0000, "R5 set blocked");
    // R5 plain write clears lock bits only
    wr(8'h00, 32'h0000_00FF);
    rd(8'h00, 32'h0000_0000, "R5 unlock keeps fields");
    // R2 plain write, undefined bits masked
    wr(8'h00, 32'h0000_FFF5);
    rd(8'h00, 32'h0000_1FF5, "R2 plain");
    rd(8'h04, 32'h0000_1FF5, "R6 via set alias");
    rd(8'h08, 32'h0000_1FF5, "R6 via clr alias");
    // R4 clear alias
    wr(8'h08, 32'h0000_0F00);
    rd(8'h00, 32'h0000_10F5, "R4 clr");
    // R3 set alias
    wr(8'h04, 32'h0000_000A);
    rd(8'h00, 32'h0000_10FF, "R3 set");
    chk_ctrl(32'h0000_10FF, "R3 ctrl_o");
    // R6 reserved offset and unmapped
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R6 reserved read");
    rd(8'h00, 32'h0000_10FF, "R6 reserved write ignored");
    rd(8'h20, 32'h0, "R6 unmapped");
    // R7 busy
    busy = 1'b1;
    rd(8'h10, 32'h1, "R7 busy high");
    wr(8'h18, 32'h1);
    rd(8'h10, 32'h1, "R7 busy not writable");
    busy = 1'b0;
    rd(8'h10, 32'h0, "R7 busy low");
    // R8 underflow sticky, R10 irq
    pulse(1'b1, 1'b0);
    rd(8'h10, 32'h2, "R8 underflow set");
    chk_irq(1'b1, "R10 irq on flag");
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h2);
    rd(8'h10, 32'h2, "R8 plain/set no effect");
    wr(8'h18, 32'h2);
    rd(8'h10, 32'h0, "R8 clear alias");
    chk_irq(1'b0, "R10 irq drops");
    // R9 event wins over clear
    pulse(1'b0, 1'b1);
    addr = 8'h18; wdata = 32'h4; we = 1'b1; of = 1'b1;
    @(negedge clk);
    we = 1'b0; of = 1'b0;
    rd(8'h10, 32'h4, "R9 overflow kept");
    // R10 enable gating
    wr(8'h08, 32'h2);
    chk_irq(1'b0, "R10 disabled");
    wr(8'h04, 32'h2);
    chk_irq(1'b1, "R10 re-enabled");
    // R5 re-lock via set alias, then plain write of zero
    wr(8'h04, 32'h8000_0000);
    rd(8'h00, 32'h8000_10FF, "R5 relocked");
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0000_10FF, "R5 fields held");
    chk_ctrl(32'h0000_10FF, "R5 ctrl_o");
    repeat (3) @(negedge clk);
    if (due_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: %0d checks never reached, actual %0d expected 0", due_q.size(), due_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule